// File: doc/BRIEF.md
# Configurable logic cell back end

This block is the output stage of one programmable logic cell. A sum-of-products term arrives on `sop`. It can be combined through an XOR with a separate single product term on `ptx`, and the polarity of the result can then be flipped. That logic value leaves the cell in one of two ways. It can pass straight through to `cell_out`, or it can be stored in an element that static configuration turns into a D flip-flop, a toggle flip-flop or a transparent latch. The storage element can instead be pointed at the cell's own pin input, so that it works as an input register or latch while the logic value still goes out combinationally.

Static configuration pins pick the following:
- which clock drives the storage: one of the global clocks, a shared clock or a local clock;
- the clock polarity;
- capture on one edge or on both edges;
- whether a clock enable is used;
- where the asynchronous set and the asynchronous reset each come from.

The configuration is meant to be held constant while the cell runs. Every pin is a plain level signal. The cell has no data handshake, because it has no flow control and no back-pressure. A second output, `fb_out`, carries the value that goes back to the routing fabric.

Top module: `mc_cell`

## Requirements
- R1: The logic value is `f = sop ^ (cfg_xor_en & ptx) ^ cfg_inv`. With `cfg_mode` = 0 (combinational) and `cfg_cap_pin` = 0, `cell_out` equals `f` with no clock involved.
- R2: With `cfg_mode` = 1 (D), `cfg_both` = 0 and `cfg_ce_en` = 0, `cell_out` takes the stored input at each active edge of the selected clock and holds it otherwise. The active edge is the rising edge when `cfg_clk_inv` = 0 and the falling edge when `cfg_clk_inv` = 1.
- R3: With `cfg_mode` = 2 (toggle), a stored input of 1 inverts `cell_out` at each active edge, and an input of 0 leaves it unchanged.
- R4: With `cfg_mode` = 3 (latch), `cell_out` follows the stored input while the selected clock is high (`cfg_clk_inv` = 0) or low (`cfg_clk_inv` = 1). It holds its last value while the clock is at the other level.
- R5: With `cfg_both` = 1 in D or toggle mode, both clock edges are active, and `cfg_clk_inv` has no effect on the result.
- R6: In D mode with `cfg_ce_en` = 1, an active edge with `ce` = 0 leaves `cell_out` unchanged. In toggle mode, `ce` and `cfg_ce_en` are ignored.
- R7: `cfg_clk_src` selects the clock. The codes are 0 to N_GLB-1 for `glb_clk[i]`, N_GLB for `shr_clk` and N_GLB+1 for `loc_clk` (3 and 4 by default). Edges on clocks that are not selected have no effect.
- R8: `cfg_set_src` and `cfg_rst_src` each pick their source by the same code: 0 = never, 1 = local term, 2 = shared term, 3 = `glb_init`. An active set or reset forces the stored value to 1 or 0 at once, in every storage mode and without a clock. Reset wins when both are active, and an input whose source is not selected has no effect.
- R9: With `cfg_cap_pin` = 1, the storage captures `pin_in`, `fb_out` carries the stored value and `cell_out` carries `f`. With `cfg_cap_pin` = 0, `fb_out` equals `cell_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_clk | input | N_GLB | Global clocks |
| shr_clk | input | 1 | Shared clock term |
| loc_clk | input | 1 | Local clock term |
| sop | input | 1 | Sum-of-products term |
| ptx | input | 1 | Single product term for the XOR |
| pin_in | input | 1 | Cell's own pin input |
| ce | input | 1 | Clock enable term |
| loc_set | input | 1 | Local asynchronous set term |
| loc_clr | input | 1 | Local asynchronous reset term |
| shr_set | input | 1 | Shared asynchronous set term |
| shr_clr | input | 1 | Shared asynchronous reset term |
| glb_init | input | 1 | Global set/reset line |
| cfg_mode | input | 2 | 0 combinational, 1 D, 2 toggle, 3 latch |
| cfg_xor_en | input | 1 | Enable XOR with ptx |
| cfg_inv | input | 1 | Invert logic result |
| cfg_clk_src | input | $clog2(N_GLB+2) | Clock source code |
| cfg_clk_inv | input | 1 | Clock polarity |
| cfg_both | input | 1 | Capture on both edges |
| cfg_ce_en | input | 1 | Use clock enable |
| cfg_set_src | input | 2 | Set source code |
| cfg_rst_src | input | 2 | Reset source code |
| cfg_cap_pin | input | 1 | Store pin_in instead of logic |
| cell_out | output | 1 | Data output toward the pad |
| fb_out | output | 1 | Feedback toward the routing fabric |

## Verification
The assertions sample on `glb_clk[0]` and rely on that clock running freely. The bench treats it only as a monitor clock and as its own source for one test. The checks also rely on a set and a reset never being released in the same interval in which the other one is still held, since the stored value is undefined in that overlap. The stimulus always asserts and releases them as pairs, together. The bench changes data, enable and configuration only a nanosecond or more away from an edge of the selected clock. This keeps every capture unambiguous. When the latch is checked, the selected clock is always one of the manually driven ones, never the monitor clock.

// File: rtl/mc_cell_pkg.sv
package mc_cell_pkg;

  typedef enum logic [1:0] {
    STORE_COMB  = 2'd0,
    STORE_D     = 2'd1,
    STORE_T     = 2'd2,
    STORE_LATCH = 2'd3
  } store_mode_e;

  typedef enum logic [1:0] {
    ASRC_NONE   = 2'd0,
    ASRC_LOCAL  = 2'd1,
    ASRC_SHARED = 2'd2,
    ASRC_GLOBAL = 2'd3
  } async_src_e;

endpackage

// File: rtl/mc_logic_stage.sv
module mc_logic_stage (
  input  logic sop,
  input  logic ptx,
  input  logic xor_en,
  input  logic inv,
  output logic f
);
  logic gated_pt;
  logic mixed;

  assign gated_pt = xor_en & ptx;
  assign mixed    = sop ^ gated_pt;
  assign f        = inv ? ~mixed : mixed;
endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int N_GLB = 3,
  parameter int SEL_W = $clog2(N_GLB + 2)
) (
  input  logic [N_GLB-1:0] glb_clk,
  input  logic             shr_clk,
  input  logic             loc_clk,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             ck
);
  localparam int N_SRC = N_GLB + 2;

  logic [N_SRC-1:0] srcs;
  logic             picked;

  assign srcs = {loc_clk, shr_clk, glb_clk};

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) picked = srcs[i];
    end
  end

  assign ck = picked ^ inv;
endmodule

// File: rtl/mc_async_pick.sv
module mc_async_pick
  import mc_cell_pkg::*;
(
  input  logic [1:0] src,
  input  logic       loc_term,
  input  logic       shr_term,
  input  logic       glb_term,
  output logic       act
);
  async_src_e code;

  assign code = async_src_e'(src);

  always_comb begin
    unique case (code)
      ASRC_LOCAL:  act = loc_term;
      ASRC_SHARED: act = shr_term;
      ASRC_GLOBAL: act = glb_term;
      default:     act = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_cell_pkg::*;
#(
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic       ck,
  input  logic [1:0] mode,
  input  logic       both_edge,
  input  logic       ce_en,
  input  logic       ce,
  input  logic       din,
  input  logic       pre,
  input  logic       clr,
  output logic       q
);
  store_mode_e md;
  logic        qp;
  logic        qn;
  logic        ql;
  logic        both_act;
  logic        cur_p;
  logic        cur_n;
  logic        nxt_p;
  logic        nxt_n;
  logic        ce_ok;
  logic        ff_q;
  logic        held;

  assign md    = store_mode_e'(mode);
  assign ce_ok = (md != STORE_D) || !ce_en || ce;

  // The value each edge register sees as "current" is the one showing just
  // before its edge: with both edges active that is the other register.
  assign cur_p = both_act ? qn : qp;
  assign cur_n = qp;

  function automatic logic next_val(input store_mode_e m, input logic cur,
                                    input logic d, input logic en);
    if (m == STORE_T) return cur ^ d;
    return en ? d : cur;
  endfunction

  assign nxt_p = next_val(md, cur_p, din, ce_ok);
  assign nxt_n = next_val(md, cur_n, din, ce_ok);

  always_ff @(posedge ck or posedge clr or posedge pre) begin
    if (clr)      qp <= 1'b0;
    else if (pre) qp <= 1'b1;
    else          qp <= nxt_p;
  end

  generate
    if (BOTH_EDGE_EN) begin : g_both
      assign both_act = both_edge;
      always_ff @(negedge ck or posedge clr or posedge pre) begin
        if (clr)      qn <= 1'b0;
        else if (pre) qn <= 1'b1;
        else          qn <= nxt_n;
      end
      assign ff_q = both_act ? (ck ? qp : qn) : qp;
    end else begin : g_single
      logic unused_both;
      assign unused_both = both_edge ^ nxt_n;
      assign both_act    = 1'b0;
      assign qn          = qp;
      assign ff_q        = qp;
    end
  endgenerate

  always_latch begin
    if (clr)      ql = 1'b0;
    else if (pre) ql = 1'b1;
    else if (ck)  ql = din;
  end

  assign held = (md == STORE_LATCH) ? ql : ff_q;

  // Asynchronous controls show at the output while they are held.
  always_comb begin
    if (clr)      q = 1'b0;
    else if (pre) q = 1'b1;
    else          q = held;
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_cell_pkg::*;
#(
  parameter int N_GLB        = 3,
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic [N_GLB-1:0]            glb_clk,
  input  logic                        shr_clk,
  input  logic                        loc_clk,
  input  logic                        sop,
  input  logic                        ptx,
  input  logic                        pin_in,
  input  logic                        ce,
  input  logic                        loc_set,
  input  logic                        loc_clr,
  input  logic                        shr_set,
  input  logic                        shr_clr,
  input  logic                        glb_init,
  input  logic [1:0]                  cfg_mode,
  input  logic                        cfg_xor_en,
  input  logic                        cfg_inv,
  input  logic [$clog2(N_GLB+2)-1:0]  cfg_clk_src,
  input  logic                        cfg_clk_inv,
  input  logic                        cfg_both,
  input  logic                        cfg_ce_en,
  input  logic [1:0]                  cfg_set_src,
  input  logic [1:0]                  cfg_rst_src,
  input  logic                        cfg_cap_pin,
  output logic                        cell_out,
  output logic                        fb_out
);
  localparam int SEL_W = $clog2(N_GLB + 2);

  logic f;
  logic ck;
  logic pre;
  logic clr;
  logic din;
  logic q;

  mc_logic_stage u_logic (
    .sop    (sop),
    .ptx    (ptx),
    .xor_en (cfg_xor_en),
    .inv    (cfg_inv),
    .f      (f)
  );

  mc_clk_pick #(.N_GLB(N_GLB), .SEL_W(SEL_W)) u_clk (
    .glb_clk (glb_clk),
    .shr_clk (shr_clk),
    .loc_clk (loc_clk),
    .sel     (cfg_clk_src),
    .inv     (cfg_clk_inv),
    .ck      (ck)
  );

  mc_async_pick u_set (
    .src      (cfg_set_src),
    .loc_term (loc_set),
    .shr_term (shr_set),
    .glb_term (glb_init),
    .act      (pre)
  );

  mc_async_pick u_rst (
    .src      (cfg_rst_src),
    .loc_term (loc_clr),
    .shr_term (shr_clr),
    .glb_term (glb_init),
    .act      (clr)
  );

  assign din = cfg_cap_pin ? pin_in : f;

  mc_store #(.BOTH_EDGE_EN(BOTH_EDGE_EN)) u_store (
    .ck        (ck),
    .mode      (cfg_mode),
    .both_edge (cfg_both),
    .ce_en     (cfg_ce_en),
    .ce        (ce),
    .din       (din),
    .pre       (pre),
    .clr       (clr),
    .q         (q)
  );

  assign cell_out = (store_mode_e'(cfg_mode) == STORE_COMB || cfg_cap_pin) ? f : q;
  assign fb_out   = cfg_cap_pin ? q : cell_out;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
  parameter int N_GLB = 3
) (
  input logic [N_GLB-1:0]           glb_clk,
  input logic                       shr_clk,
  input logic                       loc_clk,
  input logic                       sop,
  input logic                       ptx,
  input logic                       ce,
  input logic                       loc_set,
  input logic                       loc_clr,
  input logic                       shr_set,
  input logic                       shr_clr,
  input logic                       glb_init,
  input logic [1:0]                 cfg_mode,
  input logic                       cfg_xor_en,
  input logic                       cfg_inv,
  input logic [$clog2(N_GLB+2)-1:0] cfg_clk_src,
  input logic                       cfg_clk_inv,
  input logic                       cfg_both,
  input logic                       cfg_ce_en,
  input logic [1:0]                 cfg_set_src,
  input logic [1:0]                 cfg_rst_src,
  input logic                       cfg_cap_pin,
  input logic                       cell_out
);
  logic [1:0] seen = 2'd0;
  logic       armed;
  logic       set_on;
  logic       clr_on;
  logic       f_exp;
  logic       lvl;
  logic       stored;
  logic       hold_c;
  logic [N_GLB+1:0] srcs;

  always_ff @(posedge glb_clk[0]) begin
    if (seen != 2'd3) seen <= seen + 2'd1;
  end
  assign armed = (seen == 2'd3);

  function automatic logic pick(input logic [1:0] s, input logic l,
                                input logic h, input logic g);
    case (s)
      2'd1:    return l;
      2'd2:    return h;
      2'd3:    return g;
      default: return 1'b0;
    endcase
  endfunction

  assign set_on = pick(cfg_set_src, loc_set, shr_set, glb_init);
  assign clr_on = pick(cfg_rst_src, loc_clr, shr_clr, glb_init);
  assign f_exp  = sop ^ (cfg_xor_en & ptx) ^ cfg_inv;
  assign srcs   = {loc_clk, shr_clk, glb_clk};
  assign lvl    = (32'(cfg_clk_src) < N_GLB + 2) ? (srcs[cfg_clk_src] ^ cfg_clk_inv) : cfg_clk_inv;
  assign stored = (cfg_mode != 2'd0) && !cfg_cap_pin;
  assign hold_c = (cfg_mode == 2'd1) && cfg_ce_en && !ce && !cfg_cap_pin && !set_on && !clr_on;

  p_comb_func_r1: assert property (@(posedge glb_clk[0]) disable iff (!armed)
    (cfg_mode == 2'd0 && !cfg_cap_pin) |-> (cell_out == f_exp));

  p_clr_wins_r8: assert property (@(posedge glb_clk[0]) disable iff (!armed)
    (stored && clr_on) |-> (cell_out == 1'b0));

  p_set_forces_r8: assert property (@(posedge glb_clk[0]) disable iff (!armed)
    (stored && set_on && !clr_on) |-> (cell_out == 1'b1));

  p_ce_hold_r6: assert property (@(posedge glb_clk[0]) disable iff (!armed || set_on || clr_on)
    (hold_c && $past(hold_c) && $stable(cfg_both) && $stable(cfg_mode)) |-> $stable(cell_out));

  p_latch_open_r4: assert property (@(posedge glb_clk[0]) disable iff (!armed || set_on || clr_on)
    (cfg_mode == 2'd3 && !cfg_cap_pin && cfg_clk_src != '0 && lvl) |-> (cell_out == f_exp));

  p_pin_pass_r9: assert property (@(posedge glb_clk[0]) disable iff (!armed)
    cfg_cap_pin |-> (cell_out == f_exp));
endmodule

bind mc_cell mc_cell_chk #(.N_GLB(N_GLB)) u_chk (
  .glb_clk     (glb_clk),
  .shr_clk     (shr_clk),
  .loc_clk     (loc_clk),
  .sop         (sop),
  .ptx         (ptx),
  .ce          (ce),
  .loc_set     (loc_set),
  .loc_clr     (loc_clr),
  .shr_set     (shr_set),
  .shr_clr     (shr_clr),
  .glb_init    (glb_init),
  .cfg_mode    (cfg_mode),
  .cfg_xor_en  (cfg_xor_en),
  .cfg_inv     (cfg_inv),
  .cfg_clk_src (cfg_clk_src),
  .cfg_clk_inv (cfg_clk_inv),
  .cfg_both    (cfg_both),
  .cfg_ce_en   (cfg_ce_en),
  .cfg_set_src (cfg_set_src),
  .cfg_rst_src (cfg_rst_src),
  .cfg_cap_pin (cfg_cap_pin),
  .cell_out    (cell_out)
);

// File: tb/tb_mc_cell.sv
`timescale 1ns/100ps
module tb_mc_cell;
  logic clk = 1'b0, g1 = 1'b0, g2 = 1'b0, sclk = 1'b0, lclk = 1'b0;
  logic sop = 1'b0, ptx = 1'b0, pin = 1'b0, ce = 1'b0;
  logic lset = 1'b0, lclr = 1'b0, sset = 1'b0, sclr = 1'b0, ginit = 1'b1;
  logic [1:0] cfg_mode = 2'd1;
  logic cfg_xor_en = 1'b0, cfg_inv = 1'b0, cfg_clk_inv = 1'b0, cfg_both = 1'b0;
  logic cfg_ce_en = 1'b0, cfg_cap_pin = 1'b0;
  logic [2:0] cfg_clk_src = 3'd1;
  logic [1:0] cfg_set_src = 2'd0, cfg_rst_src = 2'd3;
  logic cell_out, fb_out;
  logic [2:0] gclk;
  int total = 0, fails = 0;
  bit done = 1'b0;

  assign gclk = {g2, g1, clk};
  always #2.5 clk = ~clk;

  mc_cell dut (
    .glb_clk(gclk), .shr_clk(sclk), .loc_clk(lclk), .sop(sop), .ptx(ptx),
    .pin_in(pin), .ce(ce), .loc_set(lset), .loc_clr(lclr), .shr_set(sset),
    .shr_clr(sclr), .glb_init(ginit), .cfg_mode(cfg_mode), .cfg_xor_en(cfg_xor_en),
    .cfg_inv(cfg_inv), .cfg_clk_src(cfg_clk_src), .cfg_clk_inv(cfg_clk_inv),
    .cfg_both(cfg_both), .cfg_ce_en(cfg_ce_en), .cfg_set_src(cfg_set_src),
    .cfg_rst_src(cfg_rst_src), .cfg_cap_pin(cfg_cap_pin),
    .cell_out(cell_out), .fb_out(fb_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic cur(input int s);
    case (s)
      1: return g1;
      2: return g2;
      3: return sclk;
      default: return lclk;
    endcase
  endfunction

  task automatic setclk(input int s, input logic v);
    case (s)
      1: g1 = v;
      2: g2 = v;
      3: sclk = v;
      default: lclk = v;
    endcase
    #1;
  endtask

  task automatic clear_cell();
    ginit = 1'b1; #1; ginit = 1'b0; #1;
  endtask

  // Eight clock toggles on source s with a bench-side model of the stored value.
  task automatic run(input int s, input logic [1:0] md, input bit dual, input bit inv,
                     input bit cen, input logic [7:0] pat, input logic [7:0] cepat,
                     input string tag);
    logic exp;
    logic v;
    bit act;
    cfg_mode = md; cfg_both = dual; cfg_clk_inv = inv; cfg_ce_en = cen;
    cfg_clk_src = 3'(s); cfg_set_src = 2'd0; cfg_rst_src = 2'd3; cfg_cap_pin = 1'b0;
    cfg_xor_en = 1'b0; cfg_inv = 1'b0;
    g1 = 0; g2 = 0; sclk = 0; lclk = 0; sop = 0; ce = 0; #1;
    clear_cell();
    exp = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sop = pat[k]; ce = cepat[k]; #1;
      if (md == 2'd3 && (cur(s) != inv)) exp = sop;
      chk({tag, " data change"}, cell_out, exp);
      for (int o = 1; o <= 4; o++) if (o != s) setclk(o, ~cur(o));
      chk("R7 unselected clock edge", cell_out, exp);
      v = ~cur(s);
      setclk(s, v);
      act = dual || (v != inv);
      if (md == 2'd1 && act && (!cen || ce)) exp = sop;
      if (md == 2'd2 && act && sop) exp = ~exp;
      if (md == 2'd3 && (v != inv)) exp = sop;
      chk({tag, " after edge"}, cell_out, exp);
      chk("R9 feedback equals output", fb_out, cell_out);
    end
  endtask

  initial begin
    #1;
    chk("R8 reset state under global init", cell_out, 1'b0);
    ginit = 1'b0;
    @(negedge clk);

    // R1: every combination of the logic inputs in combinational mode
    cfg_mode = 2'd0;
    for (int i = 0; i < 16; i++) begin
      {sop, ptx, cfg_xor_en, cfg_inv} = 4'(i); #1;
      chk("R1 logic value", cell_out, sop ^ (cfg_xor_en & ptx) ^ cfg_inv);
      chk("R9 feedback in comb mode", fb_out, cell_out);
    end

    // R2/R3/R4/R5/R6/R7 sweeps over sources, polarity and modes
    for (int s = 1; s <= 4; s++) begin
      for (int inv = 0; inv < 2; inv++) begin
        run(s, 2'd1, 0, inv[0], 0, 8'b1011_0010, 8'h00, "R2 D single edge");
        run(s, 2'd2, 0, inv[0], 0, 8'b1101_0110, 8'h00, "R3 toggle");
        run(s, 2'd3, 0, inv[0], 0, 8'b0110_1011, 8'h00, "R4 latch");
        run(s, 2'd1, 1, inv[0], 0, 8'b1001_1101, 8'h00, "R5 D both edges");
        run(s, 2'd2, 1, inv[0], 0, 8'b1110_0101, 8'h00, "R5 toggle both edges");
        run(s, 2'd1, 0, inv[0], 1, 8'b1010_1101, 8'b0110_0101, "R6 D clock enable");
        run(s, 2'd1, 1, inv[0], 1, 8'b0111_0110, 8'b1001_1011, "R6 D enable both edges");
        run(s, 2'd2, 0, inv[0], 1, 8'b1011_0111, 8'b0000_0000, "R6 toggle ignores enable");
      end
    end

    // R7: free-running global clock 0 as the source
    cfg_mode = 2'd1; cfg_both = 0; cfg_clk_inv = 0; cfg_ce_en = 0; cfg_clk_src = 3'd0;
    cfg_xor_en = 0; cfg_inv = 0;
    @(negedge clk); clear_cell(); sop = 1'b1;
    @(posedge clk); #1;
    chk("R7 global clock 0 captures", cell_out, 1'b1);
    sop = 1'b0; @(negedge clk); #1;
    chk("R7 global clock 0 falling edge ignored", cell_out, 1'b1);
    @(posedge clk); #1;
    chk("R7 global clock 0 second capture", cell_out, 1'b0);

    // R8: each source encoding for reset and set
    @(negedge clk);
    cfg_clk_src = 3'd1; g1 = 0; #1;
    for (int r = 1; r <= 3; r++) begin
      cfg_rst_src = 2'(r); cfg_set_src = 2'd0;
      sop = 1'b1; setclk(1, 1); setclk(1, 0);
      chk("R8 loaded one", cell_out, 1'b1);
      case (r) 1: lclr = 1; 2: sclr = 1; default: ginit = 1; endcase
      #1; chk("R8 reset source acts", cell_out, 1'b0);
      lclr = 0; sclr = 0; ginit = 0; #1;
      chk("R8 reset stays after release", cell_out, 1'b0);
      cfg_rst_src = 2'd0; cfg_set_src = 2'(r); sop = 1'b0;
      case (r) 1: lset = 1; 2: sset = 1; default: ginit = 1; endcase
      #1; chk("R8 set source acts", cell_out, 1'b1);
      lset = 0; sset = 0; ginit = 0; #1;
      chk("R8 set stays after release", cell_out, 1'b1);
    end
    cfg_set_src = 2'd0; cfg_rst_src = 2'd0;
    lclr = 1; sclr = 1; ginit = 1; #1;
    chk("R8 unselected resets ignored", cell_out, 1'b1);
    lclr = 0; sclr = 0; ginit = 0; #1;
    cfg_set_src = 2'd1; cfg_rst_src = 2'd1;
    lset = 1; lclr = 1; #1;
    chk("R8 reset wins over set", cell_out, 1'b0);
    lset = 0; lclr = 0; #1;
    chk("R8 after joint release", cell_out, 1'b0);
    cfg_mode = 2'd3; g1 = 0; #1;
    lset = 1; #1;
    chk("R8 set in latch mode", cell_out, 1'b1);
    lset = 0; #1;

    // R9: pin capture
    cfg_set_src = 2'd0; cfg_rst_src = 2'd3; cfg_mode = 2'd1; cfg_cap_pin = 1'b1;
    clear_cell();
    pin = 1'b1; sop = 1'b0; setclk(1, 1); setclk(1, 0);
    chk("R9 feedback holds pin", fb_out, 1'b1);
    chk("R9 output carries logic", cell_out, 1'b0);
    pin = 1'b0; sop = 1'b1; #1;
    chk("R9 output follows logic", cell_out, 1'b1);
    chk("R9 pin change without edge", fb_out, 1'b1);
    setclk(1, 1);
    chk("R9 pin captured at edge", fb_out, 1'b0);
    cfg_mode = 2'd3; pin = 1'b1; #1;
    chk("R9 pin through open latch", fb_out, 1'b1);
    setclk(1, 0); pin = 1'b0; #1;
    chk("R9 pin latch holds", fb_out, 1'b1);
    cfg_cap_pin = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule